// File: doc/BRIEF.md
# Sleep Mode Wakeup Controller

This block manages the low-power states of a small CPU core. A 16-bit configuration register carries a 2-bit sleep-mode field. When the core raises an idle request, the block latches the field and closes clock gates for the CPU, the peripherals, a real-time-clock domain and the oscillator. The gates it closes depend on the selected mode: plain idle stops only the CPU clock, sleep with a running real-time clock also stops the peripherals, and deep sleep stops everything.

While asleep, the block watches an interrupt request and a non-maskable trap. It decides how execution continues from the global interrupt enable, the request's own enable, a comparison of the request level with the CPU priority, and a per-request transfer-enable flag. There are three outcomes. Execution can resume after the idle instruction, or branch to the service routine. The third outcome is a single peripheral-event transfer, after which the block returns to sleep without waking the CPU. Once the end-of-initialisation event has occurred, configuration writes are locked. Only a key write placed directly before the write reopens the register for that one write.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After synchronous reset, `cfg_rdata` reads 0000h, all four clock enables are 1 and the `resume_o`, `branch_o` and `xfer_o` pulses are 0.
- R2: The mode field sits at register bits 9:8. All other read bits are always 0. An accepted write is visible on `cfg_rdata` in the cycle after the write strobe.
- R3: After `init_done`, a write is ignored unless the write just before it carried the key value A5C3h. The key write itself leaves the register unchanged. Any accepted or rejected write re-arms the lock. A write in the same cycle as `init_done` is still accepted.
- R4: An `idle_req` while running gates the clocks from the next cycle, with gates given as {cpu, per, rtc, osc}. Mode 00 gives 0111, mode 01 gives 0011, and mode 11 gives 0000. The reserved mode 10 behaves as 00.
- R5: The mode is latched when sleep is entered. A write in the same cycle as `idle_req` does not affect that sleep, and neither does a write during sleep.
- R6: An NMI during sleep produces a one-cycle `branch_o` and all clocks on, in the next cycle, regardless of any enable or priority.
- R7: An individually enabled request with global enable 0 produces `resume_o` and all clocks on.
- R8: A fully enabled request whose level is not above the CPU priority (equal included) produces `resume_o`.
- R9: A fully enabled request with its level above the CPU priority and its transfer flag clear produces `branch_o`. At most one outcome pulse is ever high.
- R10: A fully enabled request with its level above the CPU priority and its transfer flag set produces exactly one `xfer_o` cycle, with gates {0, 1, rtc, 1}, where rtc is 0 only in mode 11. The block then returns to the latched sleep gating with the CPU still stopped.
- R11: A request with its individual enable at 0 leaves the block asleep with no pulse. Requests and NMI while running produce no pulse.
- R12: When an NMI and a transfer-qualified request arrive in the same cycle, the outcome is `branch_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration register value |
| init_done | input | 1 | End-of-initialisation event, arms the write lock |
| idle_req | input | 1 | Idle instruction executed |
| glb_ie | input | 1 | Global interrupt enable |
| cpu_lvl | input | 4 | Current CPU priority level |
| irq_req | input | 1 | Interrupt request |
| irq_ie | input | 1 | Individual enable of the request |
| irq_lvl | input | 4 | Priority level of the request |
| irq_xfer | input | 1 | Transfer enabled for the request |
| nmi | input | 1 | Non-maskable trap |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| rtc_clk_en | output | 1 | Real-time-clock domain enable |
| osc_en | output | 1 | Oscillator enable |
| resume_o | output | 1 | Pulse: continue after the idle instruction |
| branch_o | output | 1 | Pulse: enter the service routine |
| xfer_o | output | 1 | Pulse: perform one event transfer |

## Verification
A configuration write and sleep entry can fall in the same clock cycle. The bench drives `cfg_wr` carrying a new mode together with `idle_req`, and the expected sleep gating must follow the old field while `cfg_rdata` shows the new one. An NMI and a transfer-qualified request are also raised together, and a write is placed in the same cycle as `init_done`. A behavioural model compares every output on every clock to judge these cases.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_XFER} pst_t;
  typedef enum logic [1:0] {OUT_NONE, OUT_RESUME, OUT_BRANCH, OUT_XFER} wake_t;

  localparam logic [1:0] MODE_IDLE = 2'b00;
  localparam logic [1:0] MODE_RTC  = 2'b01;
  localparam logic [1:0] MODE_RSV  = 2'b10;
  localparam logic [1:0] MODE_DEEP = 2'b11;

  // gate vector order: {cpu, per, rtc, osc}
  function automatic logic [3:0] gates_for(pst_t st, logic [1:0] mode);
    logic deep;
    deep = (mode == MODE_DEEP);
    case (st)
      ST_SLEEP: begin
        if (mode == MODE_IDLE) gates_for = 4'b0111;
        else if (mode == MODE_RTC) gates_for = 4'b0011;
        else gates_for = 4'b0000;
      end
      ST_XFER:  gates_for = {1'b0, 1'b1, !deep, 1'b1};
      default:  gates_for = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/swc_cfg_reg.sv
module swc_cfg_reg #(
  parameter int DW = 16,
  parameter int FIELD_LSB = 8,
  parameter logic [DW-1:0] KEY = 16'hA5C3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          init_done,
  output logic [1:0]    mode,
  output logic [DW-1:0] rdata
);
  logic [1:0] mode_q;
  logic       locked_q, open_q;
  logic       key_hit, accept;

  assign key_hit = locked_q && !open_q && (wdata == KEY);
  assign accept  = wr && !key_hit && (!locked_q || open_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= 2'b00;
      locked_q <= 1'b0;
      open_q   <= 1'b0;
    end else begin
      if (accept) mode_q <= wdata[FIELD_LSB +: 2];
      if (init_done) begin
        locked_q <= 1'b1;
        open_q   <= 1'b0;
      end else if (wr) begin
        open_q <= key_hit;
      end
    end
  end

  always_comb begin
    rdata = '0;
    rdata[FIELD_LSB +: 2] = mode_q;
  end
  assign mode = mode_q;

  assert_locked_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (locked_q && !open_q && wr && (wdata != KEY)) |=> $stable(mode_q));
endmodule

// File: rtl/swc_decide.sv
module swc_decide
  import swc_pkg::*;
#(
  parameter int LW = 4
) (
  input  logic          nmi,
  input  logic          irq_req,
  input  logic          irq_ie,
  input  logic          glb_ie,
  input  logic [LW-1:0] irq_lvl,
  input  logic [LW-1:0] cpu_lvl,
  input  logic          irq_xfer,
  output wake_t         outcome
);
  always_comb begin
    outcome = OUT_NONE;
    if (nmi) outcome = OUT_BRANCH;
    else if (irq_req && irq_ie) begin
      if (!glb_ie || (irq_lvl <= cpu_lvl)) outcome = OUT_RESUME;
      else if (irq_xfer) outcome = OUT_XFER;
      else outcome = OUT_BRANCH;
    end
  end
endmodule

// File: rtl/swc_power_fsm.sv
module swc_power_fsm
  import swc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idle_req,
  input  logic [1:0] mode,
  input  wake_t      outcome,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       rtc_clk_en,
  output logic       osc_en,
  output logic       resume_o,
  output logic       branch_o,
  output logic       xfer_o
);
  pst_t       st_q, st_n;
  logic [1:0] lat_q, lat_n;
  logic       res_n, br_n, xf_n;

  always_comb begin
    st_n  = st_q;
    lat_n = lat_q;
    res_n = 1'b0;
    br_n  = 1'b0;
    xf_n  = 1'b0;
    case (st_q)
      ST_RUN: if (idle_req) begin
        st_n  = ST_SLEEP;
        lat_n = (mode == MODE_RSV) ? MODE_IDLE : mode;
      end
      ST_SLEEP: case (outcome)
        OUT_RESUME: begin st_n = ST_RUN;  res_n = 1'b1; end
        OUT_BRANCH: begin st_n = ST_RUN;  br_n  = 1'b1; end
        OUT_XFER:   begin st_n = ST_XFER; xf_n  = 1'b1; end
        default: ;
      endcase
      default: st_n = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_RUN;
      lat_q <= MODE_IDLE;
      {cpu_clk_en, per_clk_en, rtc_clk_en, osc_en} <= 4'b1111;
      {resume_o, branch_o, xfer_o} <= 3'b000;
    end else begin
      st_q  <= st_n;
      lat_q <= lat_n;
      {cpu_clk_en, per_clk_en, rtc_clk_en, osc_en} <= gates_for(st_n, lat_n);
      {resume_o, branch_o, xfer_o} <= {res_n, br_n, xf_n};
    end
  end

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({resume_o, branch_o, xfer_o}));
  assert_sleep_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && idle_req) |=> !cpu_clk_en);
  assert_xfer_single_R10: assert property (@(posedge clk) disable iff (rst)
    xfer_o |=> (!xfer_o && !cpu_clk_en));
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int DW = 16,
  parameter int LW = 4,
  parameter int FIELD_LSB = 8,
  parameter logic [DW-1:0] KEY = 16'hA5C3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          init_done,
  input  logic          idle_req,
  input  logic          glb_ie,
  input  logic [LW-1:0] cpu_lvl,
  input  logic          irq_req,
  input  logic          irq_ie,
  input  logic [LW-1:0] irq_lvl,
  input  logic          irq_xfer,
  input  logic          nmi,
  output logic          cpu_clk_en,
  output logic          per_clk_en,
  output logic          rtc_clk_en,
  output logic          osc_en,
  output logic          resume_o,
  output logic          branch_o,
  output logic          xfer_o
);
  logic [1:0] mode;
  wake_t      outcome;

  swc_cfg_reg #(.DW(DW), .FIELD_LSB(FIELD_LSB), .KEY(KEY)) u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_wdata),
    .init_done(init_done), .mode(mode), .rdata(cfg_rdata));

  swc_decide #(.LW(LW)) u_dec (
    .nmi(nmi), .irq_req(irq_req), .irq_ie(irq_ie), .glb_ie(glb_ie),
    .irq_lvl(irq_lvl), .cpu_lvl(cpu_lvl), .irq_xfer(irq_xfer),
    .outcome(outcome));

  swc_power_fsm u_fsm (
    .clk(clk), .rst(rst), .idle_req(idle_req), .mode(mode),
    .outcome(outcome), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .rtc_clk_en(rtc_clk_en), .osc_en(osc_en), .resume_o(resume_o),
    .branch_o(branch_o), .xfer_o(xfer_o));

  // asleep and not transferring: an NMI must branch next cycle
  assert_nmi_branch_R6: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk_en && !xfer_o && nmi) |=> (branch_o && cpu_clk_en));
  assert_ignored_req_R11: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk_en && !xfer_o && !nmi && !(irq_req && irq_ie)) |=> !cpu_clk_en);
endmodule

// File: tb/sleep_wake_ctrl_tb.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_tb;
  localparam logic [15:0] KEY = 16'hA5C3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, cfg_wr = 0, init_done = 0, idle_req = 0, glb_ie = 0;
  logic irq_req = 0, irq_ie = 0, irq_xfer = 0, nmi = 0;
  logic [15:0] cfg_wdata = '0, cfg_rdata;
  logic [3:0]  cpu_lvl = '0, irq_lvl = '0;
  logic cpu_clk_en, per_clk_en, rtc_clk_en, osc_en, resume_o, branch_o, xfer_o;

  sleep_wake_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .init_done(init_done), .idle_req(idle_req),
    .glb_ie(glb_ie), .cpu_lvl(cpu_lvl), .irq_req(irq_req), .irq_ie(irq_ie),
    .irq_lvl(irq_lvl), .irq_xfer(irq_xfer), .nmi(nmi),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .rtc_clk_en(rtc_clk_en),
    .osc_en(osc_en), .resume_o(resume_o), .branch_o(branch_o), .xfer_o(xfer_o));

  int checks = 0, fails = 0;
  string tag = "R1";
  bit started = 0, done = 0;

  // behavioural reference model
  int m_mode, m_old, m_st, m_lat;
  bit m_lock, m_open, m_res, m_br, m_xf;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_lock = 0; m_open = 0; m_st = 0; m_lat = 0;
      m_res = 0; m_br = 0; m_xf = 0;
    end else begin
      m_old = m_mode;
      m_res = 0; m_br = 0; m_xf = 0;
      if (cfg_wr) begin
        if (m_lock && !m_open && cfg_wdata == KEY) m_open = 1;
        else begin
          if (!m_lock || m_open) m_mode = int'(cfg_wdata[9:8]);
          m_open = 0;
        end
      end
      if (init_done) begin m_lock = 1; m_open = 0; end
      if (m_st == 0) begin
        if (idle_req) begin m_st = 1; m_lat = (m_old == 2) ? 0 : m_old; end
      end else if (m_st == 1) begin
        if (nmi) begin m_st = 0; m_br = 1; end
        else if (irq_req && irq_ie) begin
          if (!glb_ie || irq_lvl <= cpu_lvl) begin m_st = 0; m_res = 1; end
          else if (irq_xfer) begin m_st = 2; m_xf = 1; end
          else begin m_st = 0; m_br = 1; end
        end
      end else m_st = 1;
    end
  end

  function automatic logic [3:0] exp_gates(int st, int lat);
    if (st == 0) return 4'b1111;
    if (st == 2) return {1'b0, 1'b1, lat != 3, 1'b1};
    if (lat == 0) return 4'b0111;
    if (lat == 1) return 4'b0011;
    return 4'b0000;
  endfunction

  logic [22:0] got, expv;
  always @(negedge clk) if (started && !done) begin
    got  = {cfg_rdata, cpu_clk_en, per_clk_en, rtc_clk_en, osc_en, resume_o, branch_o, xfer_o};
    expv = {16'(m_mode << 8), exp_gates(m_st, m_lat), m_res, m_br, m_xf};
    checks++;
    if (got !== expv) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, expv, $time);
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(logic [15:0] v);
    @(negedge clk); cfg_wr = 1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 0;
  endtask
  task automatic idle;
    @(negedge clk); idle_req = 1;
    @(negedge clk); idle_req = 0;
  endtask
  task automatic irq(logic [3:0] lvl, logic ie, logic g, logic [3:0] cl, logic xf);
    @(negedge clk); irq_req = 1; irq_lvl = lvl; irq_ie = ie; glb_ie = g; cpu_lvl = cl; irq_xfer = xf;
    @(negedge clk); irq_req = 0;
  endtask
  task automatic trap;
    @(negedge clk); nmi = 1;
    @(negedge clk); nmi = 0;
  endtask
  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #400000;
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL %s: watchdog expired, got hang expected completion", tag);
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 0; started = 1;
    tag = "R1"; cyc(2);
    tag = "R2"; wr(16'h0100); wr(16'hFFFF); wr(16'h0200); wr(16'h0000); cyc(1);
    tag = "R4"; idle(); cyc(2);
    tag = "R7"; irq(4'd5, 1, 0, 4'd2, 0); cyc(2);
    tag = "R11"; irq(4'd9, 1, 1, 4'd1, 0); trap(); idle(); irq(4'd9, 0, 1, 4'd1, 0); cyc(2);
    tag = "R6"; wr(16'h0100); trap(); cyc(1);
    tag = "R4"; idle(); cyc(2);
    tag = "R6"; trap(); cyc(2);
    tag = "R8"; wr(16'h0300); idle(); cyc(1); irq(4'd4, 1, 1, 4'd4, 0); cyc(2);
    tag = "R9"; wr(16'h0200); idle(); cyc(1); irq(4'd7, 1, 1, 4'd3, 0); cyc(2);
    tag = "R10"; wr(16'h0300); idle(); irq(4'd8, 1, 1, 4'd2, 1); cyc(3);
    wr(16'h0100); idle(); irq(4'd8, 1, 1, 4'd2, 1); cyc(2); irq(4'd8, 1, 1, 4'd2, 0); cyc(2);
    tag = "R12"; idle();
    @(negedge clk); nmi = 1; irq_req = 1; irq_ie = 1; glb_ie = 1; irq_lvl = 4'd9; cpu_lvl = 4'd1; irq_xfer = 1;
    @(negedge clk); nmi = 0; irq_req = 0; irq_xfer = 0; cyc(2);
    tag = "R5";
    @(negedge clk); idle_req = 1; cfg_wr = 1; cfg_wdata = 16'h0300;
    @(negedge clk); idle_req = 0; cfg_wr = 0; cyc(2);
    wr(16'h0000); cyc(2); trap(); idle(); cyc(2); trap(); cyc(1);
    tag = "R3";
    @(negedge clk); init_done = 1; cfg_wr = 1; cfg_wdata = 16'h0100;
    @(negedge clk); init_done = 0; cfg_wr = 0;
    wr(16'h0300); wr(KEY); cyc(2); wr(16'h0300); wr(16'h0000);
    wr(KEY); wr(KEY); wr(16'h0000); cyc(3);
    done = 1;
    summary();
    $finish;
  end
endmodule